// File: doc/BRIEF.md
# Constant-Time Modular Exponentiator

This block raises a base to an exponent modulo n, producing `base^expo mod n`. The same datapath serves both directions of an RSA-style exchange: encrypting a message with the public exponent and decrypting a ciphertext with the private one. Operands are 16 bits wide by default. The modulus is intended to be the product of two 8-bit primes and must be at least 1.

A one-cycle `start` pulse latches the base, exponent and modulus. First, the base is reduced modulo n. Then the exponent is scanned from its most significant bit down to its least significant bit. Every bit gets a modular square followed by a modular multiply by the reduced base. The product of the multiply is kept or discarded through a select, and the step is never skipped. All multiplies use one bit-serial shift-and-add unit that runs for a fixed number of steps.

As a result, the time from `start` to `done` is a constant set only by the parameters. It is the same for every exponent, base and modulus, so timing reveals nothing about the secret exponent.

Top module: `modexp_ct`

## Requirements
- R1: For a modulus n greater than 1, `result` equals `base^expo mod n` in the cycle where `done` is high, and that value is always below n.
- R2: An exponent of 0 yields 1 mod n: the value 1 for n greater than 1, and 0 for n equal to 1.
- R3: A base greater than or equal to n is reduced first, so the result equals `(base mod n)^expo mod n`.
- R4: `done` rises exactly (2·EXP_W+1)·(DATA_W+2) clock cycles after the edge that accepts `start` (594 cycles with the defaults). This count does not depend on the exponent, the base or the modulus.
- R5: `done` is high for exactly one cycle. `result` then holds its value until the next accepted `start`.
- R6: A `start` pulse, or a change on the operand inputs, while the block is busy has no effect on the result or on the completion time.
- R7: `busy` is high from the cycle after `start` is accepted. It falls in the same cycle that `done` rises.
- R8: After a synchronous reset, `busy`, `done` and `result` are all 0.
- R9: Encrypting with exponent e and then decrypting the output with exponent d returns the original message, when e·d ≡ 1 mod φ(n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accepts the operands when the block is idle |
| base | input | DATA_W | Message or ciphertext, any value |
| expo | input | EXP_W | Exponent, scanned from its most significant bit first |
| modulus | input | DATA_W | Modulus n, at least 1 |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse; `result` is valid |
| result | output | DATA_W | base^expo mod n |

## Verification
The sweep pairs several moduli (1, 2, small semiprimes and a full-width semiprime) with several exponents: zero, one, all ones, a sparse pattern with only its end bits set, and a mixed pattern. Each of these is combined with bases of zero, two, n−1 and all ones. Zero and all-ones exponents stand at opposite extremes of how many multiply results are kept. The all-ones base separates a correct pre-reduction from a missing one. The bench measures the latency of every run, and any difference between exponent patterns would expose a data-dependent path. A round trip with a matched key pair, together with a run that receives a spurious start pulse while busy, exercises the encrypt/decrypt symmetry and the input lockout.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RED  = 2'd1,
        ST_SQR  = 2'd2,
        ST_MUL  = 2'd3
    } ctl_state_t;

    // Cycles from the accepting edge to the edge that raises done:
    // one reduction plus two products per exponent bit, each product
    // taking a load step, dw shift steps and one hand-off step.
    function automatic int modexp_latency(int dw, int ew);
        return (2 * ew + 1) * (dw + 2);
    endfunction

endpackage

// File: rtl/modmul_serial.sv
module modmul_serial #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [DATA_W-1:0] modn,
    output logic              fin,
    output logic [DATA_W-1:0] prod
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam int TW = DATA_W + 1;

    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;
    logic              run_q;
    logic              fin_q;
    logic [DATA_W-1:0] step_val;

    // One step: acc = 2*acc (mod n), then add op_a when the multiplier
    // bit is set (mod n). Both operands of each sum stay below 2n, so a
    // single conditional subtract per stage keeps the result below n.
    always_comb begin
        logic [TW-1:0] dbl;
        logic [TW-1:0] sum;
        dbl = {acc_q, 1'b0};
        if (dbl >= {1'b0, modn}) dbl = dbl - {1'b0, modn};
        sum = dbl + (sh_q[DATA_W-1] ? {1'b0, op_a} : '0);
        if (sum >= {1'b0, modn}) sum = sum - {1'b0, modn};
        step_val = sum[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            sh_q  <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                acc_q <= '0;
                sh_q  <= op_b;
                cnt_q <= CW'(DATA_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                acc_q <= step_val;
                sh_q  <= sh_q << 1;
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin  = fin_q;
    assign prod = acc_q;

    // R1: the partial product never leaves the residue range
    p_acc_reduced_r1: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (acc_q < modn));
    // R4: completion only after every shift step has been spent
    p_fixed_steps_r4: assert property (@(posedge clk) disable iff (rst)
        fin_q |-> (cnt_q == '0 && !run_q));
    // R6: a new product is never requested over a running one
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        go |-> !run_q);
endmodule

// File: rtl/exp_scan.sv
module exp_scan #(
    parameter int EXP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [EXP_W-1:0] exp_in,
    input  logic             advance,
    output logic             cur_bit,
    output logic             last
);
    localparam int IW = $clog2(EXP_W + 1);

    logic [EXP_W-1:0] sh_q;
    logic [IW-1:0]    idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= exp_in;
            idx_q <= IW'(EXP_W - 1);
        end else if (advance) begin
            sh_q  <= sh_q << 1;
            idx_q <= idx_q - IW'(1);
        end
    end

    assign cur_bit = sh_q[EXP_W-1];
    assign last    = (idx_q == '0);

    // R4: the scan never runs past the least significant bit
    p_scan_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        advance |-> !last);
    // R6: a reload never coincides with a scan step
    p_scan_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(load && advance));
endmodule

// File: rtl/modexp_ct.sv
module modexp_ct
    import modexp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EXP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] base,
    input  logic [EXP_W-1:0]  expo,
    input  logic [DATA_W-1:0] modulus,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    localparam int LAT_CYC = modexp_latency(DATA_W, EXP_W);
    localparam int LW      = $clog2(LAT_CYC + 1);

    ctl_state_t        st_q;
    logic [DATA_W-1:0] n_q;
    logic [DATA_W-1:0] bred_q;
    logic [DATA_W-1:0] r_q;
    logic [DATA_W-1:0] res_q;
    logic [DATA_W-1:0] ma_q;
    logic [DATA_W-1:0] mb_q;
    logic              go_q;
    logic              done_q;
    logic [LW-1:0]     lat_q;

    logic              mul_fin;
    logic [DATA_W-1:0] mul_prod;
    logic              bit_now;
    logic              bit_last;
    logic              accept;
    logic              scan_adv;
    logic [DATA_W-1:0] one_val;
    logic [DATA_W-1:0] kept;

    assign accept   = (st_q == ST_IDLE) && start;
    assign scan_adv = (st_q == ST_MUL) && mul_fin && !bit_last;
    assign one_val  = (n_q == DATA_W'(1)) ? '0 : DATA_W'(1);
    // Select, never skip: the multiply always runs, the bit only picks
    assign kept     = bit_now ? mul_prod : r_q;

    modmul_serial #(.DATA_W(DATA_W)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .go   (go_q),
        .op_a (ma_q),
        .op_b (mb_q),
        .modn (n_q),
        .fin  (mul_fin),
        .prod (mul_prod)
    );

    exp_scan #(.EXP_W(EXP_W)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .exp_in  (expo),
        .advance (scan_adv),
        .cur_bit (bit_now),
        .last    (bit_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            n_q    <= '0;
            bred_q <= '0;
            r_q    <= '0;
            res_q  <= '0;
            ma_q   <= '0;
            mb_q   <= '0;
            go_q   <= 1'b0;
            done_q <= 1'b0;
            lat_q  <= '0;
        end else begin
            go_q   <= 1'b0;
            done_q <= 1'b0;
            if (st_q != ST_IDLE) lat_q <= lat_q + LW'(1);
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        // reduce the raw base as 1 * base mod n
                        n_q   <= modulus;
                        ma_q  <= DATA_W'(1);
                        mb_q  <= base;
                        go_q  <= 1'b1;
                        lat_q <= '0;
                        st_q  <= ST_RED;
                    end
                end
                ST_RED: begin
                    if (mul_fin) begin
                        bred_q <= mul_prod;
                        r_q    <= one_val;
                        ma_q   <= one_val;
                        mb_q   <= one_val;
                        go_q   <= 1'b1;
                        st_q   <= ST_SQR;
                    end
                end
                ST_SQR: begin
                    if (mul_fin) begin
                        r_q  <= mul_prod;
                        ma_q <= mul_prod;
                        mb_q <= bred_q;
                        go_q <= 1'b1;
                        st_q <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    if (mul_fin) begin
                        r_q <= kept;
                        if (bit_last) begin
                            res_q  <= kept;
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            ma_q <= kept;
                            mb_q <= kept;
                            go_q <= 1'b1;
                            st_q <= ST_SQR;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st_q != ST_IDLE);
    assign done   = done_q;
    assign result = res_q;

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R4: completion lands on the fixed cycle count
    p_fixed_latency_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == LW'(LAT_CYC)));
    // R6: operands latched at acceptance are untouched while busy
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(n_q) && $stable(bred_q)));
    // R1: the delivered value is a residue of the latched modulus
    p_result_reduced_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> ((n_q == DATA_W'(1)) ? (result == '0) : (result < n_q)));
    // R7: busy drops exactly when done rises
    p_busy_done_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

// File: tb/tb_modexp_ct.sv
`timescale 1ns/1ps
module tb_modexp_ct;
    localparam int DW  = 16;
    localparam int EW  = 16;
    localparam int LAT = (2 * EW + 1) * (DW + 2);

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [DW-1:0] base;
    logic [EW-1:0] expo;
    logic [DW-1:0] modulus;
    logic          busy;
    logic          done;
    logic [DW-1:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    modexp_ct #(.DATA_W(DW), .EXP_W(EW)) dut (
        .clk(clk), .rst(rst), .start(start), .base(base), .expo(expo),
        .modulus(modulus), .busy(busy), .done(done), .result(result)
    );

    function automatic longint ref_pow(longint b, longint e, longint n);
        longint r = 1 % n;
        longint x = b % n;
        for (int i = EW - 1; i >= 0; i--) begin
            r = (r * r) % n;
            if (e[i]) r = (r * x) % n;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input longint b, input longint e, input longint n,
                          input bit inject, output longint res, output int lat);
        int cnt;
        @(negedge clk);
        base = DW'(b); expo = EW'(e); modulus = DW'(n); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        base = '1; expo = '1; modulus = DW'(7);
        check(busy == 1'b1, "R7 busy after accept", longint'(busy), 1);
        cnt = 0;
        while (!done && cnt < 3000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (inject && cnt == 10) begin
                start = 1'b1; base = DW'(3); expo = EW'(5); modulus = DW'(11);
            end
            if (inject && cnt == 11) start = 1'b0;
        end
        check(busy == 1'b0, "R7 busy low with done", longint'(busy), 0);
        res = longint'(result);
        lat = cnt;
    endtask

    task automatic sweep_case(input longint b, input longint e, input longint n);
        longint r;
        longint exp_r;
        int lat;
        run_op(b, e, n, 1'b0, r, lat);
        exp_r = ref_pow(b, e, n);
        if (e == 0)      check(r == exp_r, "R2 zero exponent", r, exp_r);
        else if (b >= n) check(r == exp_r, "R3 base reduced", r, exp_r);
        else             check(r == exp_r, "R1 power mod n", r, exp_r);
        check(lat == LAT, "R4 fixed latency", lat, LAT);
    endtask

    initial begin
        #760000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        longint mods [6] = '{1, 2, 15, 221, 3233, 60491};
        longint exps [5] = '{0, 1, 16'hFFFF, 16'h8001, 16'h2C35};
        longint r, c, m2, held;
        int lat;
        rst = 1'b1; start = 1'b0; base = '0; expo = '0; modulus = DW'(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R8 reset busy", longint'(busy), 0);
        check(done == 1'b0, "R8 reset done", longint'(done), 0);
        check(result == '0, "R8 reset result", longint'(result), 0);
        rst = 1'b0;

        foreach (mods[i]) begin
            longint bases [4];
            bases = '{0, 2, mods[i] - 1, 16'hFFFF};
            foreach (exps[j])
                foreach (bases[k])
                    sweep_case(bases[k], exps[j], mods[i]);
        end

        // R2 with n = 1 gives 0, with n > 1 gives 1 (covered above); extra explicit case
        run_op(5, 0, 143, 1'b0, r, lat);
        check(r == 1, "R2 exponent zero gives one", r, 1);

        // R5: single-cycle done and held result
        held = r;
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", longint'(done), 0);
        repeat (5) @(negedge clk);
        check(longint'(result) == held, "R5 result held", longint'(result), held);

        // R6: start pulse while busy is ignored
        run_op(12345, 16'h2C35, 60491, 1'b1, r, lat);
        check(r == ref_pow(12345, 16'h2C35, 60491), "R6 ignored start result", r,
              ref_pow(12345, 16'h2C35, 60491));
        check(lat == LAT, "R6 ignored start latency", lat, LAT);
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R6 no restart after done", longint'(busy), 0);

        // R9: round trip, n = 251*241, e = 7, d = 17143
        run_op(16'hBEEF, 7, 60491, 1'b0, c, lat);
        check(c == ref_pow(16'hBEEF, 7, 60491), "R9 encrypt", c, ref_pow(16'hBEEF, 7, 60491));
        run_op(c, 17143, 60491, 1'b0, m2, lat);
        check(m2 == 16'hBEEF, "R9 decrypt round trip", m2, 16'hBEEF);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule